// File: doc/BRIEF.md
# Serial-Bus Control Register Bank for a Video Processing Chain

This block is an I2C target that accepts only writes. A bus master sends three bytes in each transaction: the device address, then a register selector, then a data value. The block stores the value in one of eighteen 8-bit control registers. Those registers hold the gains, biases, trims and mode flags of a video processing chain. A fast system clock oversamples SCL and SDA, and the block pulls SDA low, open-drain, to acknowledge a byte.

Writes do not reach the outputs directly. Each write lands in a shadow copy. The shadow is copied to the live register image only while the vertical-blank input is high, so picture settings never change in the visible part of a field.

A write to selector 0x00 stores nothing. It is a command that starts the horizontal loop, and it is obeyed only when a gating flag in the last register is clear. Most registers carry a 6-bit level in their low bits. The block also presents these levels as a separate vector for the converters that follow it.

Top module: `vidctl_i2c_regbank`

## Requirements
- R1: With the device address byte 0x8A, SDA is held low during the ninth clock of the address byte, of the selector byte and of the data byte. The block changes SDA only while SCL is low.
- R2: Any other address byte, including the read form 0x8B, is not acknowledged. The rest of that transaction is not acknowledged and has no effect.
- R3: A start condition (SDA falls while SCL is high) restarts byte reception, even in the middle of a transaction or in the middle of a byte.
- R4: Byte k of `reg_image_o` (bits 8k+7..8k) holds the register with selector 0x77+k, for k from 0 to 17. A write changes the shadow copy only. `reg_image_o` takes the shadow contents only in cycles where `vblank_i` is high, and holds its value otherwise.
- R5: A selector outside 0x77..0x88 and other than 0x00 is still acknowledged, but its data byte changes no register. A fourth byte in a transaction is not acknowledged and is not stored; selectors do not advance.
- R6: Bit 7 of the register at 0x87 is always 0 in the image, whatever value was written.
- R7: A data byte written to selector 0x00 gives `hloop_start_o` high for exactly one cycle, and only if bit 6 of the live 0x88 register is 0. That write stores nothing.
- R8: Field k of `dac_level_o` (bits 6k+5..6k) equals bits 5..0 of live register k for the level registers (0x78, 0x79, 0x7D..0x88). It is 0 for 0x77, 0x7A, 0x7B and 0x7C.
- R9: After reset all registers read 0x00, SDA is released and no start pulse is given.
- R10: A stop condition (SDA rises while SCL is high) returns the block to idle. Bytes that follow without a new start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| vblank_i | input | 1 | Vertical blanking; high allows the shadow-to-live copy |
| reg_image_o | output | 144 | Live register image, byte k = selector 0x77+k |
| dac_level_o | output | 108 | 6-bit level fields, field k from register k |
| hloop_start_o | output | 1 | One-cycle horizontal loop start strobe |

## Verification
The bench goes after four corner cases:

- **Blanking gate.** It writes outside blanking and confirms the image holds. A design that copied on write would move the picture in the visible region.
- **Transaction framing.** It sends a repeated start in the middle of a byte, a fourth byte, and a byte after a stop with no new start. A design that kept its bit count across a start would store a misaligned value. A design that auto-incremented would overwrite the next register. A design that failed to idle after a stop would acknowledge stray bytes.
- **Command gating.** It issues the 0x00 command with the 0x88 flag set and then with it clear. A design that ignored the flag would restart the loop when it should not, and a longer pulse would be counted twice.
- **Masked bit and level view.** It writes 0xFF to 0x87 and checks that bit 7 reads 0. It also checks that level fields are blank for the flag-only registers.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK_WAIT,
      ST_ACK_DRV,
      ST_IGNORE
   } rx_state_t;

   typedef struct packed {
      logic       valid;
      logic [7:0] sel;
      logic [7:0] data;
   } wr_req_t;

endpackage

// File: rtl/vcr_line_sync.sv
module vcr_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic q_d
);
   if (STAGES < 2) begin : g_bad_stages
      $error("vcr_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{RST_VAL}};
         q_d  <= RST_VAL;
      end else begin
         pipe <= {pipe[STAGES-2:0], d};
         q_d  <= pipe[STAGES-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/vcr_byte_rx.sv
module vcr_byte_rx
   import vcr_pkg::*;
#(
   parameter logic [7:0] DEV_ADDR   = 8'h8A,
   parameter int         XFER_BYTES = 3
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl,
   input  logic    scl_d,
   input  logic    sda,
   input  logic    sda_d,
   output logic    sda_oe,
   output wr_req_t wr
);
   localparam int IDX_W = $clog2(XFER_BYTES + 1);

   if (XFER_BYTES != 3) begin : g_bad_len
      $error("vcr_byte_rx: only three-byte transfers are supported");
   end

   rx_state_t        state;
   logic [2:0]       bit_cnt;
   logic [IDX_W-1:0] byte_idx;
   logic [7:0]       shreg;
   logic [7:0]       sel_q;
   logic [7:0]       nxt_byte;
   logic             scl_rise, scl_fall, start_ev, stop_ev;

   assign scl_rise = scl & ~scl_d;
   assign scl_fall = ~scl & scl_d;
   assign start_ev = scl & scl_d & sda_d & ~sda;
   assign stop_ev  = scl & scl_d & ~sda_d & sda;
   assign nxt_byte = {shreg[6:0], sda};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         byte_idx <= '0;
         shreg    <= '0;
         sel_q    <= '0;
         sda_oe   <= 1'b0;
         wr       <= '0;
      end else begin
         wr.valid <= 1'b0;
         if (start_ev) begin
            state    <= ST_RX;
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
         end else if (stop_ev) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg   <= nxt_byte;
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) begin
                        if (byte_idx == '0) begin
                           state <= (nxt_byte == DEV_ADDR) ? ST_ACK_WAIT : ST_IGNORE;
                        end else if (byte_idx == IDX_W'(1)) begin
                           sel_q <= nxt_byte;
                           state <= ST_ACK_WAIT;
                        end else begin
                           wr    <= '{valid: 1'b1, sel: sel_q, data: nxt_byte};
                           state <= ST_ACK_WAIT;
                        end
                     end
                  end
               end
               ST_ACK_WAIT: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b1;
                     state  <= ST_ACK_DRV;
                  end
               end
               ST_ACK_DRV: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     if (byte_idx == IDX_W'(XFER_BYTES - 1)) begin
                        state <= ST_IGNORE;
                     end else begin
                        byte_idx <= byte_idx + IDX_W'(1);
                        state    <= ST_RX;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R1: SDA may only start or stop being pulled while SCL is low
   p_oe_rise_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl);
   p_oe_fall_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> (!scl || start_ev || stop_ev));
   // R2: no acknowledge once the transfer is being ignored
   p_ignore_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> !sda_oe);
endmodule

// File: rtl/vcr_regbank.sv
module vcr_regbank
   import vcr_pkg::*;
#(
   parameter int                NUM_REGS = 18,
   parameter logic [7:0]        SEL_BASE = 8'h77,
   parameter logic [7:0]        CMD_SEL  = 8'h00,
   parameter int                GATE_IDX = 17,
   parameter int                GATE_BIT = 6,
   parameter int                ZERO_IDX = 16,
   parameter int                ZERO_BIT = 7,
   parameter int                DAC_W    = 6,
   parameter logic [NUM_REGS-1:0] DAC_MASK = 18'b11_1111_1111_1100_0110
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  wr_req_t                     wr,
   input  logic                        vblank,
   output logic [NUM_REGS*8-1:0]       live_flat,
   output logic [NUM_REGS*DAC_W-1:0]   dac_flat,
   output logic                        hloop_start
);
   localparam int IDX_W   = $clog2(NUM_REGS);
   localparam int SEL_END = int'(SEL_BASE) + NUM_REGS;

   if (SEL_END > 256) begin : g_bad_map
      $error("vcr_regbank: register window runs past selector 0xFF");
   end
   if (int'(CMD_SEL) >= int'(SEL_BASE) && int'(CMD_SEL) < SEL_END) begin : g_bad_cmd
      $error("vcr_regbank: command selector overlaps register window");
   end
   if (DAC_W < 1 || DAC_W > 8) begin : g_bad_dac
      $error("vcr_regbank: DAC_W must be 1..8");
   end
   if (GATE_IDX >= NUM_REGS || ZERO_IDX >= NUM_REGS) begin : g_bad_idx
      $error("vcr_regbank: special register index out of range");
   end

   logic             in_win;
   logic [IDX_W-1:0] wr_idx;
   logic             gate_live;

   assign in_win    = ({1'b0, wr.sel} >= {1'b0, SEL_BASE}) && (int'(wr.sel) < SEL_END);
   assign wr_idx    = IDX_W'(wr.sel - SEL_BASE);
   assign gate_live = live_flat[GATE_IDX*8 + GATE_BIT];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [7:0] KEEP = (i == ZERO_IDX) ? ~(8'h01 << ZERO_BIT) : 8'hFF;
      logic [7:0] shadow_q;
      logic [7:0] live_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q <= '0;
            live_q   <= '0;
         end else begin
            if (wr.valid && in_win && (wr_idx == IDX_W'(i))) begin
               shadow_q <= wr.data & KEEP;
            end
            if (vblank) begin
               live_q <= shadow_q;
            end
         end
      end

      assign live_flat[i*8 +: 8] = live_q;

      if (DAC_MASK[i]) begin : g_dac
         assign dac_flat[i*DAC_W +: DAC_W] = live_q[DAC_W-1:0];
      end else begin : g_flag
         assign dac_flat[i*DAC_W +: DAC_W] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hloop_start <= 1'b0;
      else        hloop_start <= wr.valid && (wr.sel == CMD_SEL) && !gate_live;
   end

   // R4: the live image is frozen outside blanking
   p_live_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !vblank |=> $stable(live_flat));
   // R6: masked bit never shows in the image
   p_masked_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      live_flat[ZERO_IDX*8 + ZERO_BIT] == 1'b0);
   // R7: strobe is a single cycle and respects the gate flag
   p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hloop_start |=> !hloop_start);
   p_pulse_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hloop_start |-> $past(!gate_live));
endmodule

// File: rtl/vidctl_i2c_regbank.sv
module vidctl_i2c_regbank
   import vcr_pkg::*;
#(
   parameter logic [7:0] DEV_ADDR    = 8'h8A,
   parameter int         SYNC_STAGES = 2,
   parameter int         NUM_REGS    = 18,
   parameter logic [7:0] SEL_BASE    = 8'h77,
   parameter logic [7:0] CMD_SEL     = 8'h00,
   parameter int         DAC_W       = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      scl_i,
   input  logic                      sda_i,
   output logic                      sda_oe_o,
   input  logic                      vblank_i,
   output logic [NUM_REGS*8-1:0]     reg_image_o,
   output logic [NUM_REGS*DAC_W-1:0] dac_level_o,
   output logic                      hloop_start_o
);
   logic    scl_s, scl_p, sda_s, sda_p;
   wr_req_t wr;

   vcr_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s), .q_d(scl_p));

   vcr_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s), .q_d(sda_p));

   vcr_byte_rx #(.DEV_ADDR(DEV_ADDR), .XFER_BYTES(3)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .scl(scl_s), .scl_d(scl_p), .sda(sda_s), .sda_d(sda_p),
      .sda_oe(sda_oe_o), .wr(wr));

   vcr_regbank #(
      .NUM_REGS(NUM_REGS), .SEL_BASE(SEL_BASE), .CMD_SEL(CMD_SEL),
      .GATE_IDX(NUM_REGS - 1), .GATE_BIT(6),
      .ZERO_IDX(NUM_REGS - 2), .ZERO_BIT(7),
      .DAC_W(DAC_W), .DAC_MASK(18'b11_1111_1111_1100_0110)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(wr), .vblank(vblank_i),
      .live_flat(reg_image_o), .dac_flat(dac_level_o),
      .hloop_start(hloop_start_o));
endmodule

// File: tb/vidctl_i2c_regbank_tb.sv
module vidctl_i2c_regbank_tb;
   localparam int Q  = 8;
   localparam int NR = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic vblank = 1'b0;
   logic sda_oe, hloop;
   logic sda_bus;
   logic [NR*8-1:0] img;
   logic [NR*6-1:0] dac;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int exp_pulses = 0;
   int run_len = 0;
   int max_run = 0;
   logic [7:0] sh_m [NR];
   logic [7:0] lv_m [NR];

   always #4 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   vidctl_i2c_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .vblank_i(vblank), .reg_image_o(img),
      .dac_level_o(dac), .hloop_start_o(hloop));

   always @(negedge clk) begin
      if (hloop) begin
         pulses++;
         run_len++;
         if (run_len > max_run) max_run = run_len;
      end else begin
         run_len = 0;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      scl = 1'b0; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         scl = 1'b0; tick(Q); sda_m = b[i]; tick(Q);
         scl = 1'b1; tick(2*Q); scl = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      tick(Q); sda_m = 1'b1; tick(Q);
      scl = 1'b1; tick(Q); ack = !sda_bus; tick(Q);
      scl = 1'b0; tick(Q);
   endtask

   function automatic bit sel_valid(input logic [7:0] s);
      return (s >= 8'h77) && (s <= 8'h88);
   endfunction

   function automatic logic [7:0] reg_at(input int k);
      return img[k*8 +: 8];
   endfunction

   task automatic model_write(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d);
      if (a == 8'h8A) begin
         if (sel_valid(s)) sh_m[s - 8'h77] = (s == 8'h87) ? (d & 8'h7F) : d;
         else if (s == 8'h00 && !lv_m[17][6]) exp_pulses++;
      end
   endtask

   task automatic write3(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d, output logic [2:0] acks);
      logic k;
      bus_start();
      send_byte(a, k); acks[0] = k;
      send_byte(s, k); acks[1] = k;
      send_byte(d, k); acks[2] = k;
      bus_stop();
      model_write(a, s, d);
   endtask

   task automatic check_image(input string req);
      for (int k = 0; k < NR; k++) check(reg_at(k) == lv_m[k], req, reg_at(k), lv_m[k]);
   endtask

   task automatic commit();
      vblank = 1'b1; tick(4); vblank = 1'b0; tick(2);
      for (int k = 0; k < NR; k++) lv_m[k] = sh_m[k];
   endtask

   initial begin
      tick(190000);
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [2:0] acks;
      logic k;
      void'($urandom(32'd20250611));
      for (int i = 0; i < NR; i++) begin sh_m[i] = '0; lv_m[i] = '0; end
      tick(5); rst_n = 1'b1; tick(5);

      // R9: reset state
      check(img == '0, "R9 image", img[31:0], 32'd0);
      check(!sda_oe, "R9 sda released", sda_oe, 0);
      check(pulses == 0, "R9 no pulse", pulses, 0);

      // R1 and R4: write outside blanking, then commit
      write3(8'h8A, 8'h78, 8'hC5, acks);
      check(acks == 3'b111, "R1 acks", acks, 3'b111);
      check_image("R4 hold outside blanking");
      commit();
      check_image("R4 commit");
      // R8: level view of register 0x78 and flag-only 0x77
      write3(8'h8A, 8'h77, 8'hFF, acks);
      commit();
      check(dac[6 +: 6] == 6'h05, "R8 level field", dac[6 +: 6], 6'h05);
      check(dac[0 +: 6] == 6'h00, "R8 flag register", dac[0 +: 6], 6'h00);

      // R6: bit 7 of 0x87 masked
      write3(8'h8A, 8'h87, 8'hFF, acks);
      commit();
      check(reg_at(16) == 8'h7F, "R6 masked bit", reg_at(16), 8'h7F);

      // R2: read address not acknowledged
      write3(8'h8B, 8'h80, 8'h99, acks);
      check(acks == 3'b000, "R2 read address", acks, 3'b000);
      commit(); check_image("R2 no effect");

      // R5: unmapped selector acknowledged, discarded
      write3(8'h8A, 8'h50, 8'h33, acks);
      check(acks == 3'b111, "R5 unmapped acks", acks, 3'b111);
      commit(); check_image("R5 discarded");

      // R5: fourth byte not acknowledged, no auto-increment
      bus_start();
      send_byte(8'h8A, k); send_byte(8'h80, k); send_byte(8'h11, k);
      send_byte(8'h22, k);
      check(!k, "R5 fourth byte ack", k, 0);
      bus_stop();
      model_write(8'h8A, 8'h80, 8'h11);
      commit(); check_image("R5 no increment");

      // R3: repeated start between bytes and inside a byte
      bus_start();
      send_byte(8'h8A, k); send_byte(8'h81, k);
      bus_start();
      send_byte(8'h8A, k); send_byte(8'h82, k); send_byte(8'h44, k);
      check(k, "R3 restart ack", k, 1);
      bus_start();
      send_byte(8'h8A, k); send_bits(8'hA0, 4);
      bus_start();
      send_byte(8'h8A, k); send_byte(8'h83, k); send_byte(8'h55, k);
      bus_stop();
      model_write(8'h8A, 8'h82, 8'h44);
      model_write(8'h8A, 8'h83, 8'h55);
      commit(); check_image("R3 restart");

      // R10: byte after stop without start
      send_byte(8'h8A, k);
      check(!k, "R10 idle after stop", k, 0);

      // R7: gated command
      write3(8'h8A, 8'h88, 8'h40, acks); commit();
      write3(8'h8A, 8'h00, 8'h00, acks); tick(4);
      check(pulses == exp_pulses && exp_pulses == 0, "R7 gated off", pulses, 0);
      write3(8'h8A, 8'h88, 8'h00, acks); commit();
      write3(8'h8A, 8'h00, 8'h00, acks); tick(4);
      check(pulses == 1 && exp_pulses == 1, "R7 strobe", pulses, 1);
      check_image("R7 no storage");

      // random mix
      for (int t = 0; t < 40; t++) begin
         logic [7:0] a, s, d;
         int r;
         r = $urandom % 10;
         a = 8'h8A;
         d = 8'($urandom);
         if (r <= 6)      s = 8'h77 + 8'($urandom % 18);
         else if (r == 7) s = 8'h00;
         else if (r == 8) s = 8'(1 + $urandom % 8'h76);
         else begin
            s = 8'h79;
            a = 8'($urandom);
            if (a == 8'h8A) a = 8'h8B;
         end
         write3(a, s, d, acks);
         check(acks == ((a == 8'h8A) ? 3'b111 : 3'b000), "R1 R2 random acks", acks, (a == 8'h8A) ? 3'b111 : 3'b000);
         tick(4);
         check(pulses == exp_pulses, "R7 random pulses", pulses, exp_pulses);
         if ($urandom % 2 == 0) begin
            commit(); check_image("R4 random commit");
         end else begin
            check_image("R4 random hold");
         end
      end
      commit(); check_image("R4 final");
      for (int i = 0; i < NR; i++) begin
         logic [5:0] e;
         e = (i == 0 || (i >= 3 && i <= 5)) ? 6'h0 : lv_m[i][5:0];
         check(dac[i*6 +: 6] == e, "R8 level view", dac[i*6 +: 6], e);
      end
      check(max_run <= 1, "R7 pulse width", max_run, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule